// File: doc/BRIEF.md
# Flash Page Lock Enforcer

This block guards a flash controller. Every erase or program command passes through it and is either forwarded to the controller with a start pulse or turned back with an error pulse. Permission comes from a small set of protection bytes that live at the very top of flash: the last sixteen bytes of the highest page. Each ordinary page has one permit bit in those bytes. The page that holds the bytes has no permit bit of its own. It is writable only while debug mode is active. One further bit decides whether a debug port must refuse most of its commands.

After reset the block fetches the sixteen protection bytes one at a time over a simple flash read port. Until the last byte has arrived it refuses every command. Then it raises a ready flag. A page-size select input picks 1 KB or 2 KB pages, which decides which address bits form the page number. Whole-chip erase is allowed only in debug mode.

Top module: `flk_gate`

## Requirements
- R1: After reset `lock_ready` is 0 and `dbg_ignore` is 1. The block issues read requests for the sixteen byte addresses from 2^ADDR_W-16 upward, one address per request and in rising order. `lock_ready` rises after the sixteenth byte and stays high until the next reset.
- R2: A command presented while `lock_ready` is 0 is rejected.
- R3: Each cycle with `cmd_valid` high gives exactly one of `fc_start` or `cmd_err`, as a one-cycle pulse in the next cycle. A cycle without `cmd_valid` gives neither.
- R4: Erase-page (`cmd_op`=0) and write (`cmd_op`=1) to any page other than the top page are granted only when that page's permit bit is 1. The permit bit for page 8k+b is bit b of protection byte k, where byte k is read from address 2^ADDR_W-16+k. Debug mode does not override a 0.
- R5: Erase or write to the top page (the page that holds the protection bytes) is granted exactly when `dbg_mode` is 1, whatever its own bit holds.
- R6: With `page_2k`=0 the page number is `cmd_addr[ADDR_W-1:10]`. With `page_2k`=1 it is `cmd_addr[ADDR_W-1:11]`.
- R7: Mass erase (`cmd_op`=2) is granted exactly when `dbg_mode` is 1.
- R8: The reserved code `cmd_op`=3 is always rejected.
- R9: Once ready, `dbg_ignore` equals the inverse of bit 7 of the last protection byte.
- R10: A granted command drives `fc_op` and `fc_addr` with the command's op code and address, unchanged, in the cycle of `fc_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| page_2k | input | 1 | 1 selects 2 KB pages, 0 selects 1 KB |
| dbg_mode | input | 1 | debug mode active |
| cmd_valid | input | 1 | command present this cycle |
| cmd_op | input | 2 | 0 erase page, 1 write, 2 mass erase, 3 reserved |
| cmd_addr | input | ADDR_W | byte address of the command |
| rd_req | output | 1 | protection byte read request, held until `rd_valid` |
| rd_addr | output | ADDR_W | address of the requested byte |
| rd_data | input | 8 | returned byte |
| rd_valid | input | 1 | `rd_data` valid |
| fc_start | output | 1 | start pulse to the flash controller |
| fc_op | output | 2 | op code of the granted command |
| fc_addr | output | ADDR_W | address of the granted command |
| cmd_err | output | 1 | reject pulse |
| lock_ready | output | 1 | protection bytes loaded |
| dbg_ignore | output | 1 | debug port must ignore most commands |

## Verification
A wrong stored permit bit appears one cycle after the first command aimed at that page: the start pulse and the error pulse come out swapped. The bench therefore aims commands at pages whose bits are 0 and at pages whose bits are 1, in both page sizes. A bad page-number decode shows up the same way at a page boundary. Running one address under both page sizes gives two different verdicts that only a correct shift produces. A corrupted loader index shows up as an out-of-order read address during loading, or as a wrong `dbg_ignore` level two cycles after `lock_ready` rises.

// File: rtl/flk_pkg.sv
package flk_pkg;
  typedef enum logic [1:0] {
    OP_ERASE = 2'd0,
    OP_WRITE = 2'd1,
    OP_MASS  = 2'd2,
    OP_RSVD  = 2'd3
  } flk_op_e;
endpackage

// File: rtl/flk_loader.sv
// Fetches the protection bytes after reset, keeps the permit bits and the debug bit.
module flk_loader #(
  parameter int ADDR_W     = 16,
  parameter int LOCK_BYTES = 16,
  parameter int PAGES_MAX  = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic                 rd_req,
  output logic [ADDR_W-1:0]    rd_addr,
  input  logic [7:0]           rd_data,
  input  logic                 rd_valid,
  output logic [PAGES_MAX-1:0] page_bits,
  output logic                 dbg_bit,
  output logic                 ready
);
  localparam int IDX_W      = $clog2(LOCK_BYTES);
  localparam int PAGE_BYTES = (PAGES_MAX + 7) / 8;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'((1 << ADDR_W) - LOCK_BYTES);
  localparam logic [IDX_W-1:0]  LAST = IDX_W'(LOCK_BYTES - 1);

  logic [IDX_W-1:0]        idx;
  logic [8*PAGE_BYTES-1:0] page_q;
  logic                    take;

  assign take = rd_req && rd_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req  <= 1'b0;
      idx     <= '0;
      ready   <= 1'b0;
      dbg_bit <= 1'b0;
    end else begin
      if (!ready && !rd_req) rd_req <= 1'b1;
      if (take) begin
        if (idx == LAST) begin
          dbg_bit <= rd_data[7];
          ready   <= 1'b1;
          rd_req  <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // one byte lane per permit byte
  for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) page_q[8*k +: 8] <= 8'h00;
      else if (take && idx == IDX_W'(k)) page_q[8*k +: 8] <= rd_data;
    end
  end

  assign rd_addr   = BASE + ADDR_W'(idx);
  assign page_bits = page_q[PAGES_MAX-1:0];

  a_r1_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  a_r1_quiet_when_ready: assert property (@(posedge clk) disable iff (rst)
    ready |-> !rd_req);
  a_r1_addr_held: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> $stable(rd_addr));
endmodule

// File: rtl/flk_pagemap.sv
// Turns the upper address bits into a page number for the chosen page size.
module flk_pagemap #(
  parameter int PW = 6
) (
  input  logic          big_pages,
  input  logic [PW-1:0] hi_addr,
  output logic [PW-1:0] page,
  output logic          is_top
);
  localparam logic [PW-1:0] TOP_SMALL = {PW{1'b1}};
  localparam logic [PW-1:0] TOP_BIG   = {1'b0, {(PW-1){1'b1}}};

  always_comb begin
    if (big_pages) begin
      page   = {1'b0, hi_addr[PW-1:1]};
      is_top = (page == TOP_BIG);
    end else begin
      page   = hi_addr;
      is_top = (page == TOP_SMALL);
    end
  end
endmodule

// File: rtl/flk_decide.sv
// Grant decision for one command.
module flk_decide
  import flk_pkg::*;
#(
  parameter int PW = 6
) (
  input  flk_op_e            op,
  input  logic [PW-1:0]      page,
  input  logic               is_top,
  input  logic [2**PW-1:0]   page_bits,
  input  logic               dbg_mode,
  input  logic               ready,
  output logic               grant
);
  always_comb begin
    grant = 1'b0;
    if (ready) begin
      unique case (op)
        OP_ERASE, OP_WRITE: grant = is_top ? dbg_mode : page_bits[page];
        OP_MASS:            grant = dbg_mode;
        default:            grant = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/flk_gate.sv
module flk_gate
  import flk_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SMALL_LG   = 10,
  parameter int LOCK_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              page_2k,
  input  logic              dbg_mode,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  input  logic              rd_valid,
  output logic              fc_start,
  output logic [1:0]        fc_op,
  output logic [ADDR_W-1:0] fc_addr,
  output logic              cmd_err,
  output logic              lock_ready,
  output logic              dbg_ignore
);
  localparam int PW        = ADDR_W - SMALL_LG;
  localparam int PAGES_MAX = 2 ** PW;

  logic [PAGES_MAX-1:0] page_bits;
  logic                 dbg_bit;
  logic [PW-1:0]        page;
  logic                 top_hit;
  logic                 grant;

  flk_loader #(.ADDR_W(ADDR_W), .LOCK_BYTES(LOCK_BYTES), .PAGES_MAX(PAGES_MAX)) u_load (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .page_bits(page_bits), .dbg_bit(dbg_bit), .ready(lock_ready)
  );

  flk_pagemap #(.PW(PW)) u_map (
    .big_pages(page_2k), .hi_addr(cmd_addr[ADDR_W-1:SMALL_LG]),
    .page(page), .is_top(top_hit)
  );

  flk_decide #(.PW(PW)) u_dec (
    .op(flk_op_e'(cmd_op)), .page(page), .is_top(top_hit), .page_bits(page_bits),
    .dbg_mode(dbg_mode), .ready(lock_ready), .grant(grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fc_start   <= 1'b0;
      cmd_err    <= 1'b0;
      fc_op      <= 2'd0;
      fc_addr    <= '0;
      dbg_ignore <= 1'b1;
    end else begin
      fc_start   <= cmd_valid && grant;
      cmd_err    <= cmd_valid && !grant;
      dbg_ignore <= !(lock_ready && dbg_bit);
      if (cmd_valid) begin
        fc_op   <= cmd_op;
        fc_addr <= cmd_addr;
      end
    end
  end

  a_r3_one_outcome: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> (fc_start != cmd_err));
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> (!fc_start && !cmd_err));
  a_r2_grant_needs_ready: assert property (@(posedge clk) disable iff (rst)
    fc_start |-> lock_ready);
  a_r7_mass_needs_debug: assert property (@(posedge clk) disable iff (rst)
    (fc_start && fc_op == 2'd2) |-> $past(dbg_mode));
  a_r8_reserved_never: assert property (@(posedge clk) disable iff (rst)
    fc_start |-> (fc_op != 2'd3));
  a_r5_top_needs_debug: assert property (@(posedge clk) disable iff (rst)
    (fc_start && fc_op != 2'd2 && $past(top_hit)) |-> $past(dbg_mode));
  a_r10_addr_forward: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> (fc_addr == $past(cmd_addr) && fc_op == $past(cmd_op)));
endmodule

// File: tb/tb_flk_gate.sv
`timescale 1ns/1ps
module tb_flk_gate;
  typedef struct packed {
    logic        grant;
    logic [1:0]  op;
    logic [15:0] addr;
    logic [7:0]  rq;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic page_2k = 1'b1, dbg_mode = 1'b0, cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [15:0] cmd_addr = 16'h0;
  logic rd_req, rd_valid = 1'b0;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data = 8'h0;
  logic fc_start, cmd_err, lock_ready, dbg_ignore;
  logic [1:0]  fc_op;
  logic [15:0] fc_addr;

  int checks = 0, errors = 0;
  int nreads = 0, bad_addr = 0;
  bit model_ready = 0, finished = 0;
  logic [7:0] lmem [16];
  exp_t expq[$];

  always #2 clk = ~clk;

  flk_gate dut (
    .clk(clk), .rst(rst), .page_2k(page_2k), .dbg_mode(dbg_mode), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .fc_start(fc_start), .fc_op(fc_op),
    .fc_addr(fc_addr), .cmd_err(cmd_err), .lock_ready(lock_ready), .dbg_ignore(dbg_ignore)
  );

  // flash read port model: answers one cycle after a request, records addresses (R1)
  always @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req && !rd_valid;
      rd_data  <= lmem[rd_addr[3:0]];
      if (rd_req && !rd_valid) begin
        if (rd_addr != 16'hFFF0 + 16'(nreads)) bad_addr++;
        nreads++;
      end
    end
  end

  function automatic logic model(input logic [1:0] op, input logic [15:0] addr,
                                 input logic dbg, input logic p2k);
    int pg, top;
    if (!model_ready || op == 2'd3) return 1'b0;
    if (op == 2'd2) return dbg;
    pg  = p2k ? int'(addr >> 11) : int'(addr >> 10);
    top = p2k ? 31 : 63;
    if (pg == top) return dbg;
    return lmem[pg / 8][pg % 8];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [15:0] addr, input logic dbg,
                      input logic p2k, input int rq);
    exp_t e;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; dbg_mode = dbg; page_2k = p2k;
    e.grant = model(op, addr, dbg, p2k);
    e.op = op; e.addr = addr; e.rq = rq[7:0];
    expq.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (!rst && (fc_start || cmd_err)) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R3 outcome with no command: start=%0b err=%0b expected none",
                 fc_start, cmd_err);
      end else begin
        e = expq.pop_front();
        if (fc_start !== e.grant || cmd_err !== !e.grant ||
            (e.grant && (fc_op !== e.op || fc_addr !== e.addr))) begin
          errors++;
          $display("FAIL R%0d start=%0b op=%0d addr=%h expected start=%0b op=%0d addr=%h",
                   e.rq, fc_start, fc_op, fc_addr, e.grant, e.op, e.addr);
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  task automatic reload(input logic [7:0] b0, input logic [7:0] b15);
    rst = 1'b1; model_ready = 0; nreads = 0; bad_addr = 0;
    for (int i = 0; i < 16; i++) lmem[i] = (i < 8) ? 8'hFF : 8'h00;
    lmem[0] = b0; lmem[1] = 8'h0F; lmem[7] = 8'h3F; lmem[15] = b15;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_ready();
    while (!lock_ready) @(negedge clk);
    model_ready = 1;
    repeat (2) @(negedge clk);
    check(nreads == 16 && bad_addr == 0, "R1 read sequence", nreads, 16);
  endtask

  initial begin
    reload(8'hA5, 8'h7F);
    @(negedge clk);
    check(lock_ready == 1'b0, "R1 ready low after reset", lock_ready, 0);
    check(dbg_ignore == 1'b1, "R1 dbg_ignore high after reset", dbg_ignore, 1);
    check(!fc_start && !cmd_err, "R1 no pulse after reset", fc_start, 0);
    send(2'd0, 16'h0000, 1'b1, 1'b1, 2);             // R2 before ready
    wait_ready();
    check(dbg_ignore == 1'b1, "R9 debug bit 0", dbg_ignore, 1);
    send(2'd0, 16'h0000, 1'b0, 1'b1, 4);             // R4 page0 open
    send(2'd1, 16'h0800, 1'b0, 1'b1, 4);             // R4 page1 locked
    send(2'd1, 16'h0800, 1'b1, 1'b1, 4);             // R4 debug does not override
    send(2'd1, 16'h1004, 1'b0, 1'b1, 10);            // R10 forward addr
    send(2'd0, 16'h1800, 1'b0, 1'b1, 4);             // R4 page3 locked
    send(2'd0, 16'h4000, 1'b0, 1'b1, 4);             // R4 page8 open
    send(2'd0, 16'h6000, 1'b0, 1'b1, 4);             // R4 page12 locked
    send(2'd0, 16'hF800, 1'b0, 1'b1, 5);             // R5 top page no debug
    send(2'd1, 16'hF900, 1'b1, 1'b1, 5);             // R5 top page debug
    send(2'd1, 16'h0400, 1'b0, 1'b0, 6);             // R6 1KB page1 locked
    send(2'd1, 16'h0400, 1'b0, 1'b1, 6);             // R6 2KB page0 open
    send(2'd0, 16'hF800, 1'b0, 1'b0, 6);             // R6 1KB page62 locked
    send(2'd0, 16'hF400, 1'b0, 1'b0, 6);             // R6 1KB page61 open
    send(2'd0, 16'hFC00, 1'b0, 1'b0, 5);             // R5 1KB top no debug
    send(2'd0, 16'hFC00, 1'b1, 1'b0, 5);             // R5 1KB top debug
    send(2'd2, 16'h0000, 1'b0, 1'b1, 7);             // R7 mass no debug
    send(2'd2, 16'h1234, 1'b1, 1'b1, 7);             // R7 mass debug
    send(2'd3, 16'h0000, 1'b1, 1'b1, 8);             // R8 reserved
    repeat (3) @(negedge clk);                       // R3 idle gap, no pulse expected
    reload(8'h5A, 8'hFF);
    wait_ready();
    check(dbg_ignore == 1'b0, "R9 debug bit 1", dbg_ignore, 0);
    send(2'd0, 16'h0000, 1'b0, 1'b1, 4);             // R4 reloaded page0 locked
    send(2'd0, 16'h0800, 1'b0, 1'b1, 4);             // R4 reloaded page1 open
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R3 all commands answered", expq.size(), 0);
    summary();
  end
endmodule